// File: doc/BRIEF.md
# Period-Match Interval Timer (64-bit)

This block is a general-purpose up-counting timer. Its count and its period are 64 bits wide, and each is reached as two 32-bit words on a plain register port: one write strobe, a word address, write data and combinational read data. The counter advances on ticks taken either from the block clock or from rising edges of an external pin. The external pin passes through a synchronizer before it is used. When a tick arrives while the count equals the period, the block signals a match. A match raises a maskable interrupt through a sticky status bit, sends a one-cycle DMA request, and drives an output pin as a single pulse or as a toggling clock.

Software sets the tick source, one-shot or continuous operation, the output pin behaviour and the interrupt enable in a control word. A separate global word holds an operating-mode field and a master on/off bit. In continuous operation the counter returns to zero on the match tick, and the active period is reloaded from a shadow reload register at that moment. A period value P therefore gives one match every P+1 ticks. Stopping, restarting, zeroing and switching off the timer are each done with a single register write.

Top module: `ptimer64`

## Requirements
- R1: After reset every word at addresses 0 to 9 reads zero, and irq, dma_evt and tmr_out are low.
- R2: The timer counts when all of the following hold: GLOBAL (address 1) bit 2 "on" is 1, GLOBAL bits 1:0 "mode" are 0, CONTROL (address 0) bit 0 "run" is 1, and CONTROL bit 2 "source" is 0. While counting, the count advances by exactly one per clock. The count's low word is at address 2 and its high word at address 3, and a carry passes from the low word into the high word.
- R3: With CONTROL bit 1 "continuous" set to 1, a tick that arrives while the count equals the period (addresses 4 low, 5 high) sets the count to 0 and copies the reload value (addresses 6 low, 7 high) into the period. This gives one match every P+1 ticks.
- R4: With CONTROL bit 1 set to 0 (one-shot), the match tick leaves the count at the period value and clears the CONTROL run bit.
- R5: Each match tick has three effects. dma_evt is high for exactly the next clock cycle. STATUS (address 8) bit 0 is set. irq then follows STATUS bit 0 ANDed with CONTROL bit 5 "interrupt enable".
- R6: Writing 1 to STATUS bit 0 clears it, and writing 0 leaves it unchanged. If a match occurs in the same cycle as the clearing write, the bit stays set.
- R7: With CONTROL bit 2 set to 1, ext_in passes through a two-flop synchronizer. Each rising edge then gives exactly one tick, and a steady level gives none.
- R8: Clearing the run bit holds the count and produces no match events. Setting the run bit again resumes counting from the held value.
- R9: Writing 1 to bit 0 of COMMAND (address 9) zeroes the count on the next clock and leaves the period and reload values as they were. COMMAND reads as zero.
- R10: While the on bit is 0, the count is held at zero, count writes are ignored, and the internal pin level is 0. A nonzero mode field stops counting and keeps the current count.
- R11: CONTROL bit 3 selects the pin behaviour. When it is 0 (pulse), the pin goes high on a match tick and low on the next tick. When it is 1 (clock), the pin toggles on every match. CONTROL bit 4 inverts tmr_out.
- R12: Writing a period word also writes the matching reload word. Writing a reload word changes only the reload value.
- R13: A write to one count word in the same cycle as a tick sets that word to the written value instead of the counted value. The other word keeps its old value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock, also the internal tick source |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| ext_in | input | 1 | External tick pin, asynchronous |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 4 | Word address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr, combinational |
| irq | output | 1 | Maskable interrupt (sticky status AND enable) |
| dma_evt | output | 1 | One-cycle DMA request per match |
| tmr_out | output | 1 | Timer output pin, pulse or clock, polarity selectable |

## Verification
The in-module assertions check several local rules on every cycle. They check the single-step advance and the wrap to zero, the hold and run-clear of one-shot operation, and that dma_evt follows a match by exactly one cycle and only then. They also check that status sets on a match and clears on a 1-write, that pulses on the synchronized pin never come in adjacent cycles, and that the pin toggles or drops as its mode requires. Only the bench scenarios can show the end-to-end properties. These are the P+1 tick spacing, the period reload at the wrap, the carry between the two words, the counting of external edges after synchronization, write priority over counting, and the state kept across stop, restart, zeroing and switching off.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

  // control word, bit 0 = run .. bit 5 = interrupt enable
  typedef struct packed {
    logic irq_en;
    logic out_inv;
    logic out_tog;
    logic src_ext;
    logic cont;
    logic run;
  } tmr_ctrl_t;

  localparam int unsigned CTRL_BITS = $bits(tmr_ctrl_t);
  localparam int unsigned MODE_W    = 2;

  // fixed word addresses; the remaining map is derived from the half count
  localparam int unsigned A_CTRL = 0;
  localparam int unsigned A_GLB  = 1;
  localparam int unsigned A_CNT0 = 2;

endpackage

// File: rtl/tmr_tick_src.sv
module tmr_tick_src #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_ni,
  input  logic ext_in,
  input  logic src_ext,
  output logic tick
);

  localparam int PIPE_W = SYNC_STAGES + 1;

  logic [PIPE_W-1:0] pipe_q;
  logic [PIPE_W-1:0] pipe_d;
  logic              ext_rise;

  always_comb begin
    pipe_d = {pipe_q[PIPE_W-2:0], ext_in};
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      pipe_q <= '0;
    end else begin
      pipe_q <= pipe_d;
    end
  end

  assign ext_rise = pipe_q[PIPE_W-2] & ~pipe_q[PIPE_W-1];
  assign tick     = src_ext ? ext_rise : 1'b1;

  AST_RISE_SINGLE: assert property (@(posedge clk) disable iff (!rst_ni)
    ext_rise |=> !ext_rise); // R7

endmodule

// File: rtl/tmr_regs.sv
module tmr_regs
  import tmr_pkg::*;
#(
  parameter int DW     = 32,
  parameter int NH     = 2,
  parameter int ADDR_W = 4
) (
  input  logic                 clk,
  input  logic                 rst_ni,
  input  logic                 reg_wr,
  input  logic [ADDR_W-1:0]    reg_addr,
  input  logic [CTRL_BITS-1:0] wlow,
  input  logic                 hit,
  input  logic [DW*NH-1:0]     cnt_q,
  input  logic [DW*NH-1:0]     prd_q,
  input  logic [DW*NH-1:0]     rld_q,
  output tmr_ctrl_t            ctrl_q,
  output logic [MODE_W-1:0]    mode_q,
  output logic                 active_q,
  output logic                 irq,
  output logic [NH-1:0]        wr_cnt,
  output logic [NH-1:0]        wr_prd,
  output logic [NH-1:0]        wr_rld,
  output logic                 cnt_clr,
  output logic [DW-1:0]        reg_rdata
);

  localparam int unsigned A_PRD0 = A_CNT0 + NH;
  localparam int unsigned A_RLD0 = A_PRD0 + NH;
  localparam int unsigned A_STS  = A_RLD0 + NH;
  localparam int unsigned A_CMD  = A_STS + 1;

  logic                wr_ctrl, wr_glb, wr_sts, wr_cmd;
  tmr_ctrl_t           ctrl_d;
  logic                ctrl_en;
  logic [MODE_W-1:0]   mode_d;
  logic                active_d;
  logic                sts_q, sts_d, sts_en;

  // write decode
  assign wr_ctrl = reg_wr && (reg_addr == ADDR_W'(A_CTRL));
  assign wr_glb  = reg_wr && (reg_addr == ADDR_W'(A_GLB));
  assign wr_sts  = reg_wr && (reg_addr == ADDR_W'(A_STS));
  assign wr_cmd  = reg_wr && (reg_addr == ADDR_W'(A_CMD));
  assign cnt_clr = wr_cmd && wlow[0];

  for (genvar h = 0; h < NH; h++) begin : g_dec
    assign wr_cnt[h] = reg_wr && (reg_addr == ADDR_W'(A_CNT0 + h));
    assign wr_prd[h] = reg_wr && (reg_addr == ADDR_W'(A_PRD0 + h));
    assign wr_rld[h] = reg_wr && (reg_addr == ADDR_W'(A_RLD0 + h));
  end

  // control word: software write, or one-shot self-clear of run
  always_comb begin
    ctrl_d  = ctrl_q;
    ctrl_en = wr_ctrl | (hit & ~ctrl_q.cont);
    if (wr_ctrl) begin
      ctrl_d = tmr_ctrl_t'(wlow);
    end else if (hit && !ctrl_q.cont) begin
      ctrl_d.run = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q <= '0;
    end else if (ctrl_en) begin
      ctrl_q <= ctrl_d;
    end
  end

  // global word
  always_comb begin
    mode_d   = wlow[MODE_W-1:0];
    active_d = wlow[MODE_W];
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q   <= '0;
      active_q <= 1'b0;
    end else if (wr_glb) begin
      mode_q   <= mode_d;
      active_q <= active_d;
    end
  end

  // sticky status, set wins over write-one-to-clear
  always_comb begin
    sts_en = hit | wr_sts;
    if (hit) begin
      sts_d = 1'b1;
    end else if (wr_sts && wlow[0]) begin
      sts_d = 1'b0;
    end else begin
      sts_d = sts_q;
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      sts_q <= 1'b0;
    end else if (sts_en) begin
      sts_q <= sts_d;
    end
  end

  assign irq = sts_q & ctrl_q.irq_en;

  // read mux
  always_comb begin
    reg_rdata = '0;
    if (reg_addr == ADDR_W'(A_CTRL)) reg_rdata = DW'(ctrl_q);
    if (reg_addr == ADDR_W'(A_GLB))  reg_rdata = DW'({active_q, mode_q});
    for (int h = 0; h < NH; h++) begin
      if (reg_addr == ADDR_W'(A_CNT0 + h)) reg_rdata = cnt_q[h*DW +: DW];
      if (reg_addr == ADDR_W'(A_PRD0 + h)) reg_rdata = prd_q[h*DW +: DW];
      if (reg_addr == ADDR_W'(A_RLD0 + h)) reg_rdata = rld_q[h*DW +: DW];
    end
    if (reg_addr == ADDR_W'(A_STS))  reg_rdata = DW'(sts_q);
  end

  AST_STS_SET: assert property (@(posedge clk) disable iff (!rst_ni)
    hit |=> sts_q); // R5

  AST_STS_W1C: assert property (@(posedge clk) disable iff (!rst_ni)
    (wr_sts && wlow[0] && !hit) |=> !sts_q); // R6

  AST_ONESHOT_STOP: assert property (@(posedge clk) disable iff (!rst_ni)
    (hit && !ctrl_q.cont && !wr_ctrl) |=> !ctrl_q.run); // R4

endmodule

// File: rtl/tmr_core.sv
module tmr_core #(
  parameter int DW = 32,
  parameter int NH = 2
) (
  input  logic            clk,
  input  logic            rst_ni,
  input  logic            active,
  input  logic            adv,
  input  logic            cont,
  input  logic [DW-1:0]   wdata,
  input  logic [NH-1:0]   wr_cnt,
  input  logic [NH-1:0]   wr_prd,
  input  logic [NH-1:0]   wr_rld,
  input  logic            cnt_clr,
  output logic [DW*NH-1:0] cnt_q,
  output logic [DW*NH-1:0] prd_q,
  output logic [DW*NH-1:0] rld_q,
  output logic            hit
);

  localparam int CW = DW * NH;

  logic [CW-1:0] cnt_d, prd_d;
  logic [CW-1:0] cnt_wval, prd_wval, rld_wval;
  logic          cnt_en, prd_en, rld_en;
  logic          cnt_wr_any, prd_wr_any;
  logic [NH-1:0] rld_sel;

  // word-wise merge of write data into the current values
  for (genvar h = 0; h < NH; h++) begin : g_half
    assign rld_sel[h]             = wr_prd[h] | wr_rld[h];
    assign cnt_wval[h*DW +: DW]   = wr_cnt[h]  ? wdata : cnt_q[h*DW +: DW];
    assign prd_wval[h*DW +: DW]   = wr_prd[h]  ? wdata : prd_q[h*DW +: DW];
    assign rld_wval[h*DW +: DW]   = rld_sel[h] ? wdata : rld_q[h*DW +: DW];
  end

  assign cnt_wr_any = |wr_cnt;
  assign prd_wr_any = |wr_prd;
  assign hit        = adv & (cnt_q == prd_q);

  // counter
  always_comb begin
    cnt_en = ~active | cnt_wr_any | cnt_clr | adv;
    if (!active) begin
      cnt_d = '0;
    end else if (cnt_wr_any) begin
      cnt_d = cnt_wval;
    end else if (cnt_clr) begin
      cnt_d = '0;
    end else if (hit) begin
      cnt_d = cont ? '0 : cnt_q;
    end else if (adv) begin
      cnt_d = cnt_q + 1'b1;
    end else begin
      cnt_d = cnt_q;
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  // active period, reloaded from the shadow at each continuous wrap
  always_comb begin
    prd_en = prd_wr_any | (hit & cont);
    prd_d  = prd_wr_any ? prd_wval : rld_q;
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      prd_q <= '0;
    end else if (prd_en) begin
      prd_q <= prd_d;
    end
  end

  // reload shadow
  assign rld_en = |rld_sel;

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      rld_q <= '0;
    end else if (rld_en) begin
      rld_q <= rld_wval;
    end
  end

  AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_ni)
    (adv && !hit && active && !cnt_wr_any && !cnt_clr)
      |=> (cnt_q == $past(cnt_q) + 1'b1)); // R2

  AST_WRAP_ZERO: assert property (@(posedge clk) disable iff (!rst_ni)
    (hit && cont && active && !cnt_wr_any && !cnt_clr) |=> (cnt_q == '0)); // R3

  AST_ONESHOT_HOLD: assert property (@(posedge clk) disable iff (!rst_ni)
    (hit && !cont && active && !cnt_wr_any && !cnt_clr) |=> $stable(cnt_q)); // R4

  AST_OFF_ZERO: assert property (@(posedge clk) disable iff (!rst_ni)
    !active |=> (cnt_q == '0)); // R10

  AST_STOP_HOLD: assert property (@(posedge clk) disable iff (!rst_ni)
    (!adv && active && !cnt_wr_any && !cnt_clr) |=> $stable(cnt_q)); // R8

endmodule

// File: rtl/tmr_outgen.sv
module tmr_outgen (
  input  logic clk,
  input  logic rst_ni,
  input  logic active,
  input  logic tick,
  input  logic hit,
  input  logic out_tog,
  input  logic out_inv,
  output logic dma_evt,
  output logic tmr_out
);

  logic pin_q, pin_d, pin_en;
  logic dma_q;

  always_comb begin
    pin_en = ~active | hit | (~out_tog & tick);
    if (!active) begin
      pin_d = 1'b0;
    end else if (hit) begin
      pin_d = out_tog ? ~pin_q : 1'b1;
    end else begin
      pin_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      pin_q <= 1'b0;
    end else if (pin_en) begin
      pin_q <= pin_d;
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      dma_q <= 1'b0;
    end else begin
      dma_q <= hit;
    end
  end

  assign dma_evt = dma_q;
  assign tmr_out = pin_q ^ out_inv;

  AST_DMA_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_ni)
    hit |=> dma_evt); // R5

  AST_DMA_QUIET: assert property (@(posedge clk) disable iff (!rst_ni)
    !hit |=> !dma_evt); // R5

  AST_PIN_TOGGLE: assert property (@(posedge clk) disable iff (!rst_ni)
    (hit && out_tog && active) |=> (pin_q != $past(pin_q))); // R11

  AST_PULSE_END: assert property (@(posedge clk) disable iff (!rst_ni)
    (pin_q && tick && !hit && !out_tog) |=> !pin_q); // R11

endmodule

// File: rtl/ptimer64.sv
module ptimer64
  import tmr_pkg::*;
#(
  parameter int DATA_W      = 32,
  parameter int HALVES      = 2,
  parameter int ADDR_W      = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ext_in,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic              irq,
  output logic              dma_evt,
  output logic              tmr_out
);

  localparam int CNT_W = DATA_W * HALVES;

  logic [1:0]        rst_sync_q;
  logic              rst_ni;
  tmr_ctrl_t         ctrl_q;
  logic [MODE_W-1:0] mode_q;
  logic              active_q;
  logic [HALVES-1:0] wr_cnt, wr_prd, wr_rld;
  logic              cnt_clr;
  logic [CNT_W-1:0]  cnt_q, prd_q, rld_q;
  logic              tick, running, adv, hit;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_sync_q <= '0;
    end else begin
      rst_sync_q <= {rst_sync_q[0], 1'b1};
    end
  end
  assign rst_ni = rst_sync_q[1];

  tmr_tick_src #(.SYNC_STAGES(SYNC_STAGES)) u_tick (
    .clk     (clk),
    .rst_ni  (rst_ni),
    .ext_in  (ext_in),
    .src_ext (ctrl_q.src_ext),
    .tick    (tick)
  );

  assign running = ctrl_q.run & active_q & (mode_q == '0);
  assign adv     = running & tick;

  tmr_regs #(.DW(DATA_W), .NH(HALVES), .ADDR_W(ADDR_W)) u_regs (
    .clk       (clk),
    .rst_ni    (rst_ni),
    .reg_wr    (reg_wr),
    .reg_addr  (reg_addr),
    .wlow      (reg_wdata[CTRL_BITS-1:0]),
    .hit       (hit),
    .cnt_q     (cnt_q),
    .prd_q     (prd_q),
    .rld_q     (rld_q),
    .ctrl_q    (ctrl_q),
    .mode_q    (mode_q),
    .active_q  (active_q),
    .irq       (irq),
    .wr_cnt    (wr_cnt),
    .wr_prd    (wr_prd),
    .wr_rld    (wr_rld),
    .cnt_clr   (cnt_clr),
    .reg_rdata (reg_rdata)
  );

  tmr_core #(.DW(DATA_W), .NH(HALVES)) u_core (
    .clk     (clk),
    .rst_ni  (rst_ni),
    .active  (active_q),
    .adv     (adv),
    .cont    (ctrl_q.cont),
    .wdata   (reg_wdata),
    .wr_cnt  (wr_cnt),
    .wr_prd  (wr_prd),
    .wr_rld  (wr_rld),
    .cnt_clr (cnt_clr),
    .cnt_q   (cnt_q),
    .prd_q   (prd_q),
    .rld_q   (rld_q),
    .hit     (hit)
  );

  tmr_outgen u_out (
    .clk     (clk),
    .rst_ni  (rst_ni),
    .active  (active_q),
    .tick    (tick),
    .hit     (hit),
    .out_tog (ctrl_q.out_tog),
    .out_inv (ctrl_q.out_inv),
    .dma_evt (dma_evt),
    .tmr_out (tmr_out)
  );

endmodule

// File: tb/tb_ptimer64.sv
module tb_ptimer64;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        ext_in;
  logic        reg_wr;
  logic [3:0]  reg_addr;
  logic [31:0] reg_wdata;
  logic [31:0] reg_rdata;
  logic        irq, dma_evt, tmr_out;

  always #10 clk = ~clk;

  ptimer64 dut (
    .clk(clk), .rst_n(rst_n), .ext_in(ext_in), .reg_wr(reg_wr),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .irq(irq), .dma_evt(dma_evt), .tmr_out(tmr_out)
  );

  int    n_chk  = 0;
  int    n_fail = 0;
  bit    done   = 1'b0;
  string tag    = "R1";
  logic  ext_lvl = 1'b0;

  // behavioural model state
  logic        m_run, m_cont, m_ext, m_tog, m_inv, m_ien;
  logic [1:0]  m_mode;
  logic        m_act, m_sts, m_pin, m_dma;
  logic [63:0] m_cnt, m_prd, m_rld;
  logic [2:0]  m_s;

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string t);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual %h expected %h", t, act, exp);
    end
  endtask

  function automatic logic [31:0] mdl_rd(input logic [3:0] a);
    case (a)
      4'd0: return {26'd0, m_ien, m_inv, m_tog, m_ext, m_cont, m_run};
      4'd1: return {29'd0, m_act, m_mode};
      4'd2: return m_cnt[31:0];
      4'd3: return m_cnt[63:32];
      4'd4: return m_prd[31:0];
      4'd5: return m_prd[63:32];
      4'd6: return m_rld[31:0];
      4'd7: return m_rld[63:32];
      4'd8: return {31'd0, m_sts};
      default: return 32'd0;
    endcase
  endfunction

  task automatic mdl_reset();
    {m_run, m_cont, m_ext, m_tog, m_inv, m_ien} = '0;
    m_mode = '0; m_act = 0; m_sts = 0; m_pin = 0; m_dma = 0;
    m_cnt = '0; m_prd = '0; m_rld = '0; m_s = '0;
  endtask

  task automatic mdl_step();
    logic        w, rise, tk, runn, adv, hit;
    logic [3:0]  a;
    logic [31:0] d;
    logic [63:0] n_cnt, n_prd, n_rld;
    logic [5:0]  n_ctrl;
    logic [1:0]  n_mode;
    logic        n_act, n_sts, n_pin;
    w = reg_wr; a = reg_addr; d = reg_wdata;
    rise = m_s[1] & ~m_s[2];
    tk   = m_ext ? rise : 1'b1;
    runn = m_run & m_act & (m_mode == 2'd0);
    adv  = runn & tk;
    hit  = adv & (m_cnt == m_prd);
    if (!m_act) n_cnt = '0;
    else if (w && a == 4'd2) n_cnt = {m_cnt[63:32], d};
    else if (w && a == 4'd3) n_cnt = {d, m_cnt[31:0]};
    else if (w && a == 4'd9 && d[0]) n_cnt = '0;
    else if (hit) n_cnt = m_cont ? 64'd0 : m_cnt;
    else if (adv) n_cnt = m_cnt + 64'd1;
    else n_cnt = m_cnt;
    n_prd = m_prd;
    if (w && a == 4'd4) n_prd[31:0] = d;
    else if (w && a == 4'd5) n_prd[63:32] = d;
    else if (hit && m_cont) n_prd = m_rld;
    n_rld = m_rld;
    if (w && (a == 4'd4 || a == 4'd6)) n_rld[31:0] = d;
    if (w && (a == 4'd5 || a == 4'd7)) n_rld[63:32] = d;
    n_ctrl = {m_ien, m_inv, m_tog, m_ext, m_cont, m_run};
    if (w && a == 4'd0) n_ctrl = d[5:0];
    else if (hit && !m_cont) n_ctrl[0] = 1'b0;
    n_mode = m_mode; n_act = m_act;
    if (w && a == 4'd1) begin n_mode = d[1:0]; n_act = d[2]; end
    n_sts = m_sts;
    if (hit) n_sts = 1'b1;
    else if (w && a == 4'd8 && d[0]) n_sts = 1'b0;
    n_pin = m_pin;
    if (!m_act) n_pin = 1'b0;
    else if (hit) n_pin = m_tog ? ~m_pin : 1'b1;
    else if (!m_tog && tk) n_pin = 1'b0;
    m_cnt = n_cnt; m_prd = n_prd; m_rld = n_rld;
    {m_ien, m_inv, m_tog, m_ext, m_cont, m_run} = n_ctrl;
    m_mode = n_mode; m_act = n_act; m_sts = n_sts; m_pin = n_pin;
    m_dma = hit;
    m_s = {m_s[1:0], ext_in};
  endtask

  // one clock: drive at negedge, model at posedge, compare at next negedge
  task automatic step(input logic w, input logic [3:0] a, input logic [31:0] d);
    reg_wr = w; reg_addr = a; reg_wdata = d; ext_in = ext_lvl;
    @(posedge clk);
    mdl_step();
    @(negedge clk);
    chk({31'd0, irq},     {31'd0, m_sts & m_ien},  {tag, " irq"});
    chk({31'd0, dma_evt}, {31'd0, m_dma},          {tag, " dma_evt"});
    chk({31'd0, tmr_out}, {31'd0, m_pin ^ m_inv},  {tag, " tmr_out"});
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    step(1'b1, a, d);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(1'b0, 4'd0, 32'd0);
  endtask

  task automatic rd(input logic [3:0] a, input string t);
    reg_wr = 1'b0; reg_addr = a;
    #1;
    chk(reg_rdata, mdl_rd(a), t);
  endtask

  initial begin
    void'($urandom(32'd7741));
    rst_n = 1'b0; reg_wr = 0; reg_addr = 0; reg_wdata = 0; ext_in = 0;
    mdl_reset();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    idle(3);

    // R1: reset state
    tag = "R1";
    for (int a = 0; a < 10; a++) begin
      reg_addr = a[3:0]; #1;
      chk(reg_rdata, 32'd0, "R1 reset word");
    end
    chk({29'd0, irq, dma_evt, tmr_out}, 32'd0, "R1 reset outputs");

    // R12: period write mirrors into reload; reload write stays local
    tag = "R12";
    wr(4'd4, 32'd5);
    rd(4'd4, "R12 period"); chk(reg_rdata, 32'd5, "R12 period value");
    rd(4'd6, "R12 reload mirror"); chk(reg_rdata, 32'd5, "R12 reload value");
    wr(4'd6, 32'd3);
    rd(4'd4, "R12 period kept"); chk(reg_rdata, 32'd5, "R12 period unchanged");

    // R3 / R5: continuous run on the internal clock
    tag = "R3";
    wr(4'd1, 32'h4);
    wr(4'd0, 32'h23);
    idle(40);
    rd(4'd4, "R3 reloaded period"); chk(reg_rdata, 32'd3, "R3 period after wrap");
    rd(4'd2, "R3 count");
    tag = "R5";
    rd(4'd8, "R5 status set");

    // R8: stop holds, restart resumes; R6 status clearing
    tag = "R8";
    wr(4'd0, 32'h22);
    rd(4'd2, "R8 stopped count");
    idle(6);
    rd(4'd2, "R8 held count");
    tag = "R6";
    wr(4'd8, 32'd0);
    rd(4'd8, "R6 write zero keeps"); chk(reg_rdata, 32'd1, "R6 still set");
    wr(4'd8, 32'd1);
    rd(4'd8, "R6 write one clears"); chk(reg_rdata, 32'd0, "R6 cleared");
    tag = "R8";
    wr(4'd0, 32'h23);
    idle(6);
    rd(4'd2, "R8 resumed count");

    // R2 / R13: carry across words and write priority
    tag = "R13";
    wr(4'd4, 32'hFFFF_FFFF);
    wr(4'd5, 32'hFFFF_FFFF);
    wr(4'd2, 32'hFFFF_FFFE);
    rd(4'd2, "R13 written low"); chk(reg_rdata, 32'hFFFF_FFFE, "R13 low value");
    tag = "R2";
    idle(2);
    rd(4'd3, "R2 carry high"); chk(reg_rdata, 32'd1, "R2 high word after carry");
    rd(4'd2, "R2 carry low");

    // R9: command zeroes count, leaves period
    tag = "R9";
    wr(4'd9, 32'd1);
    rd(4'd3, "R9 high zero"); rd(4'd4, "R9 period kept"); rd(4'd9, "R9 command reads zero");

    // R4: one-shot
    tag = "R4";
    wr(4'd0, 32'h0);
    wr(4'd9, 32'd1);
    wr(4'd4, 32'd6);
    wr(4'd5, 32'd0);
    wr(4'd0, 32'h21);
    idle(15);
    rd(4'd2, "R4 held at period"); chk(reg_rdata, 32'd6, "R4 count value");
    rd(4'd0, "R4 run cleared");

    // R7: external ticks
    tag = "R7";
    wr(4'd9, 32'd1);
    wr(4'd4, 32'd3);
    wr(4'd0, 32'h27);
    for (int i = 0; i < 24; i++) begin
      ext_lvl = ~ext_lvl;
      idle(1 + (i % 3));
    end
    rd(4'd2, "R7 edge count");
    ext_lvl = 1'b1;
    idle(8);
    rd(4'd2, "R7 steady level");

    // R11: pulse, clock and inverted pin
    tag = "R11";
    ext_lvl = 1'b0;
    wr(4'd0, 32'h0B);
    idle(24);
    wr(4'd0, 32'h1B);
    idle(12);
    wr(4'd0, 32'h13);
    idle(12);

    // R10: mode field halts, off forces zero
    tag = "R10";
    wr(4'd1, 32'h5);
    rd(4'd2, "R10 mode halt");
    idle(5);
    rd(4'd2, "R10 mode halt held");
    wr(4'd1, 32'h0);
    wr(4'd2, 32'd9);
    rd(4'd2, "R10 off zero"); chk(reg_rdata, 32'd0, "R10 count zero when off");
    chk({31'd0, tmr_out}, {31'd0, m_inv}, "R10 pin idle");

    // constrained random traffic
    tag = "RND";
    wr(4'd1, 32'h4);
    for (int i = 0; i < 3000; i++) begin
      logic [3:0]  a;
      logic [31:0] d;
      logic        w;
      a = 4'($urandom_range(0, 11));
      w = ($urandom_range(0, 3) == 0);
      case (a)
        4'd0: d = 32'($urandom_range(0, 63)) | 32'(($urandom_range(0, 2) != 0));
        4'd1: d = ($urandom_range(0, 7) == 0) ? 32'($urandom_range(0, 7)) : 32'h4;
        4'd2, 4'd4, 4'd6: d = 32'($urandom_range(0, 15));
        4'd3, 4'd5, 4'd7: d = ($urandom_range(0, 7) == 0) ? 32'd1 : 32'd0;
        4'd8, 4'd9: d = 32'($urandom_range(0, 1));
        default: d = $urandom;
      endcase
      if ($urandom_range(0, 2) == 0) ext_lvl = ~ext_lvl;
      step(w, a, d);
      if ((i % 4) == 0) rd(4'($urandom_range(0, 9)), "RND read");
    end

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual running expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

endmodule